// File: doc/BRIEF.md
# Capture-Compare General Purpose Timer

A 16-bit up-counter with a small register bank on a single-cycle read/write bus. The count is advanced by a clock chosen from four sources: stopped, the system clock, the system clock divided by 16, or the falling edges of an external pin. An 8-bit prescaler sits between that source and the counter. Each time the counter sits on the reference value when it is advanced, a reference match occurs. The match either lets the count run on or clears it to zero. It also drives the timer output, as a one-cycle low pulse or as a level that toggles.

A separate capture pin is watched for a rising edge, a falling edge or either edge. When a selected edge arrives, the current count is copied into the capture register. Match and capture each set a sticky flag that software clears by writing 1. A single interrupt line combines the flags with their enables. Both pins are asynchronous and pass through a two-flop synchronizer before any edge is detected.

Registers sit at a 4-byte stride. The control word at 0x0 holds these fields: bits [15:8] prescale, bits [7:6] capture edge, bit 5 output style, bit 4 match interrupt enable, bit 3 restart, bits [2:1] clock source, and bit 0 run. The other registers are the reference at 0x4, the capture at 0x8, the count at 0xC and the flags at 0x10. In the flag register, bit 1 is match and bit 0 is capture.

Top module: `gpt_timer`

## Requirements
- R1: After reset, control reads 0x0000, reference 0xFFFF, capture 0, count 0 and flags 0; the output pin is high and the interrupt is low.
- R2: With the system clock selected (source code 01) and prescale value P, the count advances once every P+1 clocks; the first advance comes P+1 clocks after run is written to 1.
- R3: Source code 10 gives one prescaler input every 16 clocks. Source code 00 never advances the count, even with run set.
- R4: Source code 11 advances the prescaler once per falling edge of the external pin. Rising edges do nothing. High and low phases of a single clock are still counted.
- R5: A match occurs when the count is advanced while it equals the reference. With restart (bit 3) at 0, the count goes on to reference+1 and wraps from 0xFFFF to 0. With restart at 1, the count goes to 0.
- R6: With output style 0, the output pin is low for exactly the one cycle after each match and high otherwise.
- R7: With output style 1, the output pin inverts after each match, starting from high.
- R8: The interrupt is high whenever the match flag is 1 and the match enable (bit 4) is 1. This includes setting the enable while the flag is already 1. It is also high whenever the capture flag is 1 and the capture edge field is not 00. The match enable does not gate the capture interrupt.
- R9: Writing a 1 to a flag bit clears that flag, and writing 0 leaves it unchanged. A new event in the same cycle wins over the clear.
- R10: While run is 0, the count, prescaler, divide-by-16 stage and output state are held at their reset values within one clock. All registers remain writable.
- R11: Capture edge code 01 captures on rising edges, 10 on falling edges, 11 on both and 00 on none. A pin change made mid-cycle after clock edge n (counted from the run write) stores the count value n+2 and sets the capture flag.
- R12: Writes to the capture and count addresses are ignored. Control and reference read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, same cycle |
| ext_clk_pin | input | 1 | Asynchronous external count clock |
| cap_pin | input | 1 | Asynchronous capture input |
| tmr_out | output | 1 | Timer output pin |
| irq | output | 1 | Interrupt request |

## Verification
The counting path is run with the prescale set to 3, with divide-by-16 combined with prescale 1, with the source stopped, and with slow and single-cycle external pin pulses. Matching the exact counts separates a divide by P from a divide by P+1, and shows which edge of the external pin is taken. Restart mode is run with small references to fix the match cycle and the pulse position. Free-run mode runs through a full 65536-count wrap. The capture pin is driven in every edge mode with both polarities, at a different cycle each time, so the stored value shows both the edge filter and the synchronizer latency.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int CNT_W  = 16;
  localparam int PS_W   = 8;
  localparam int ADDR_W = 5;
  localparam int DIV_N  = 16;

  // register index = byte address / 4
  localparam logic [2:0] IDX_CTRL = 3'd0;
  localparam logic [2:0] IDX_REF  = 3'd1;
  localparam logic [2:0] IDX_CAP  = 3'd2;
  localparam logic [2:0] IDX_CNT  = 3'd3;
  localparam logic [2:0] IDX_FLAG = 3'd4;

  typedef enum logic [1:0] {
    SRC_STOP  = 2'b00,
    SRC_SYS   = 2'b01,
    SRC_DIV16 = 2'b10,
    SRC_PIN   = 2'b11
  } clk_src_e;

  typedef enum logic [1:0] {
    CAP_OFF  = 2'b00,
    CAP_RISE = 2'b01,
    CAP_FALL = 2'b10,
    CAP_BOTH = 2'b11
  } cap_mode_e;

  typedef struct packed {
    logic [PS_W-1:0] prescale;
    cap_mode_e       cap_mode;
    logic            toggle;
    logic            match_ie;
    logic            restart;
    clk_src_e        src;
    logic            run;
  } ctrl_t;

  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] cur,
    input logic             match,
    input logic             restart
  );
    if (match && restart) return '0;
    return cur + 1'b1;
  endfunction

  function automatic logic cap_select(
    input cap_mode_e mode,
    input logic      rise,
    input logic      fall
  );
    case (mode)
      CAP_RISE: return rise;
      CAP_FALL: return fall;
      CAP_BOTH: return rise | fall;
      default:  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/gpt_edge_sync.sv
module gpt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic chg
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], din};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign lvl = sh_q[STAGES-1];
  assign chg = sh_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/gpt_tick_gen.sv
module gpt_tick_gen
  import gpt_pkg::*;
#(
  parameter int PSW = PS_W,
  parameter int DIV = DIV_N
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  clk_src_e       src,
  input  logic [PSW-1:0] prescale,
  input  logic           pin_fall,
  output logic           cnt_tick
);
  localparam int DIV_W = $clog2(DIV);

  logic [DIV_W-1:0] div_q;
  logic [PSW-1:0]   psc_q;
  logic             div_wrap;
  logic             base_tick;

  assign div_wrap = (div_q == DIV_W'(DIV - 1));

  always_comb begin
    case (src)
      SRC_SYS:   base_tick = 1'b1;
      SRC_DIV16: base_tick = div_wrap;
      SRC_PIN:   base_tick = pin_fall;
      default:   base_tick = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else if (clr) div_q <= '0;
    else div_q <= div_wrap ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psc_q <= '0;
    else if (clr) psc_q <= '0;
    else if (base_tick) psc_q <= (psc_q == prescale) ? '0 : psc_q + 1'b1;
  end

  assign cnt_tick = !clr && base_tick && (psc_q == prescale);
endmodule

// File: rtl/gpt_count_cmp.sv
module gpt_count_cmp
  import gpt_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic         restart,
  input  logic [W-1:0] ref_val,
  output logic [W-1:0] count,
  output logic         match
);
  assign match = tick && (count == ref_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (clr) count <= '0;
    else if (tick) count <= next_count(count, match, restart);
  end
endmodule

// File: rtl/gpt_timer.sv
module gpt_timer
  import gpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              ext_clk_pin,
  input  logic              cap_pin,
  output logic              tmr_out,
  output logic              irq
);
  localparam int FLAG_W = 2;

  ctrl_t              ctrl_q;
  logic [CNT_W-1:0]   ref_q;
  logic [CNT_W-1:0]   cap_q;
  logic [FLAG_W-1:0]  flag_q;
  logic [CNT_W-1:0]   count;
  logic               pulse_q;
  logic               tog_q;

  logic [2:0]         idx;
  logic               wr_en;
  logic               clr;
  logic               cnt_tick;
  logic               match;
  logic               pin_lvl, pin_chg, pin_fall;
  logic               cap_lvl, cap_chg;
  logic               cap_fire;
  logic               run_w, toggle_w, restart_w;

  assign idx       = bus_addr[ADDR_W-1:2];
  assign wr_en     = bus_sel && bus_wr;
  assign run_w     = ctrl_q.run;
  assign toggle_w  = ctrl_q.toggle;
  assign restart_w = ctrl_q.restart;
  assign clr       = !ctrl_q.run;

  gpt_edge_sync #(.STAGES(2)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_clk_pin), .lvl(pin_lvl), .chg(pin_chg)
  );
  gpt_edge_sync #(.STAGES(2)) u_cap_sync (
    .clk(clk), .rst_n(rst_n), .din(cap_pin), .lvl(cap_lvl), .chg(cap_chg)
  );
  assign pin_fall = pin_chg && !pin_lvl;

  gpt_tick_gen #(.PSW(PS_W), .DIV(DIV_N)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(clr), .src(ctrl_q.src),
    .prescale(ctrl_q.prescale), .pin_fall(pin_fall), .cnt_tick(cnt_tick)
  );

  gpt_count_cmp #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(cnt_tick),
    .restart(ctrl_q.restart), .ref_val(ref_q), .count(count), .match(match)
  );

  assign cap_fire = run_w &&
                    cap_select(ctrl_q.cap_mode, cap_chg && cap_lvl, cap_chg && !cap_lvl);

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ref_q  <= '1;
    end else if (wr_en) begin
      if (idx == IDX_CTRL) ctrl_q <= ctrl_t'(bus_wdata);
      if (idx == IDX_REF)  ref_q  <= bus_wdata;
    end
  end

  // capture register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= '0;
    else if (cap_fire) cap_q <= count;
  end

  // sticky flags: bit1 match, bit0 capture; event wins over clear
  logic [FLAG_W-1:0] flag_clr;
  assign flag_clr = (wr_en && idx == IDX_FLAG) ? bus_wdata[FLAG_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else flag_q <= (flag_q & ~flag_clr) | {match, cap_fire};
  end

  // output pin state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      tog_q   <= 1'b1;
    end else if (clr) begin
      pulse_q <= 1'b0;
      tog_q   <= 1'b1;
    end else begin
      pulse_q <= match;
      if (match) tog_q <= !tog_q;
    end
  end

  assign tmr_out = ctrl_q.toggle ? tog_q : !pulse_q;
  assign irq     = (flag_q[1] && ctrl_q.match_ie) ||
                   (flag_q[0] && (ctrl_q.cap_mode != CAP_OFF));

  always_comb begin
    case (idx)
      IDX_CTRL: bus_rdata = CNT_W'(ctrl_q);
      IDX_REF:  bus_rdata = ref_q;
      IDX_CAP:  bus_rdata = cap_q;
      IDX_CNT:  bus_rdata = count;
      IDX_FLAG: bus_rdata = CNT_W'(flag_q);
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpt_timer_chk.sv
module gpt_timer_chk
  import gpt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             run_w,
  input logic             toggle_w,
  input logic             restart_w,
  input logic             match,
  input logic             cap_fire,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] cap_q,
  input logic [1:0]       flag_q,
  input logic             tmr_out,
  input logic             irq
);
  // R5
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match && restart_w) |=> (count == '0));

  // R6
  pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!toggle_w && !tmr_out && !match) |=> (tmr_out || toggle_w));

  // R9
  match_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag_q[1]);

  // R8
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_q != 2'b00));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_w |=> (count == '0 && tmr_out));

  // R11
  capture_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> (flag_q[0] && cap_q == $past(count)));
endmodule

bind gpt_timer gpt_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run_w(run_w), .toggle_w(toggle_w),
  .restart_w(restart_w), .match(match), .cap_fire(cap_fire), .count(count),
  .cap_q(cap_q), .flag_q(flag_q), .tmr_out(tmr_out), .irq(irq)
);

// File: tb/gpt_timer_test.sv
module gpt_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_CTRL = 5'h00, A_REF = 5'h04, A_CAP = 5'h08,
                         A_CNT = 5'h0C, A_FLAG = 5'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        ext_clk_pin = 1'b0, cap_pin = 1'b0;
  logic        tmr_out, irq;

  int n_checks = 0, n_errs = 0;
  bit done = 1'b0;
  int last_cap = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpt_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_clk_pin(ext_clk_pin), .cap_pin(cap_pin), .tmr_out(tmr_out), .irq(irq)
  );

  function automatic logic [15:0] mk(int ps, int cap, int om, int ie, int rs, int src, int run);
    return 16'((ps << 8) | (cap << 6) | (om << 5) | (ie << 4) | (rs << 3) | (src << 1) | run);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #2;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output int v);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    v = int'(bus_rdata);
    bus_sel = 1'b0;
  endtask

  task automatic stop_timer();
    wr(A_CTRL, 16'h0000);
    cyc(1);
    wr(A_FLAG, 16'h0003);
  endtask

  task automatic t_reset();
    int v;
    rd(A_CTRL, v); chk("R1", "ctrl", v, 0);
    rd(A_REF, v);  chk("R1", "ref", v, 16'hFFFF);
    rd(A_CAP, v);  chk("R1", "cap", v, 0);
    rd(A_CNT, v);  chk("R1", "count", v, 0);
    rd(A_FLAG, v); chk("R1", "flags", v, 0);
    chk("R1", "out", int'(tmr_out), 1);
    chk("R1", "irq", int'(irq), 0);
  endtask

  task automatic t_prescale();
    int v;
    wr(A_CTRL, mk(3, 0, 0, 0, 0, 1, 1));
    cyc(40);
    rd(A_CNT, v); chk("R2", "count ps=3 after 40", v, 40 / 4);
    cyc(3);
    rd(A_CNT, v); chk("R2", "count ps=3 after 43", v, 43 / 4);
    wr(A_CTRL, 16'h0000);
    cyc(1);
    rd(A_CNT, v); chk("R10", "count cleared on stop", v, 0);
    wr(A_REF, 16'h0123);
    rd(A_REF, v); chk("R10", "ref writable while stopped", v, 16'h0123);
    wr(A_REF, 16'hFFFF);
  endtask

  task automatic t_sources();
    int v;
    wr(A_CTRL, mk(1, 0, 0, 0, 0, 2, 1));
    cyc(100);
    rd(A_CNT, v); chk("R3", "div16 ps=1 after 100", v, (100 / 16) / 2);
    stop_timer();
    wr(A_CTRL, mk(0, 0, 0, 0, 0, 0, 1));
    cyc(30);
    rd(A_CNT, v); chk("R3", "stopped source", v, 0);
    stop_timer();
  endtask

  task automatic t_pin();
    int v;
    wr(A_CTRL, mk(0, 0, 0, 0, 0, 3, 1));
    for (int i = 0; i < 5; i++) begin
      ext_clk_pin = 1'b1; cyc(3);
      ext_clk_pin = 1'b0; cyc(3);
    end
    cyc(4);
    rd(A_CNT, v); chk("R4", "slow pin falls", v, 5);
    for (int i = 0; i < 3; i++) begin
      ext_clk_pin = 1'b1; cyc(1);
      ext_clk_pin = 1'b0; cyc(1);
    end
    cyc(4);
    rd(A_CNT, v); chk("R4", "fast pin falls", v, 8);
    ext_clk_pin = 1'b1; cyc(5);
    rd(A_CNT, v); chk("R4", "rise not counted", v, 8);
    ext_clk_pin = 1'b0; cyc(4);
    stop_timer();
  endtask

  task automatic t_restart_pulse();
    int v, lows;
    wr(A_REF, 16'd4);
    wr(A_CTRL, mk(0, 0, 0, 1, 1, 1, 1));
    cyc(4);
    rd(A_CNT, v); chk("R5", "count before match", v, 4);
    chk("R6", "out before match", int'(tmr_out), 1);
    chk("R8", "irq before match", int'(irq), 0);
    cyc(1);
    rd(A_CNT, v); chk("R5", "restart to zero", v, 0);
    chk("R6", "out low after match", int'(tmr_out), 0);
    rd(A_FLAG, v); chk("R9", "match flag", v, 2);
    chk("R8", "irq on match", int'(irq), 1);
    cyc(1);
    chk("R6", "out back high", int'(tmr_out), 1);
    lows = 0;
    for (int i = 0; i < 20; i++) begin
      cyc(1);
      if (!tmr_out) lows++;
    end
    chk("R6", "low cycles in 20", lows, 4);
    wr(A_CTRL, 16'h0000);
    cyc(1);
  endtask

  task automatic t_irq_flags();
    int v;
    chk("R8", "irq with enable off", int'(irq), 0);
    wr(A_CTRL, mk(0, 0, 0, 1, 0, 0, 0));
    chk("R8", "irq on late enable", int'(irq), 1);
    wr(A_FLAG, 16'h0000);
    rd(A_FLAG, v); chk("R9", "write 0 keeps", v, 2);
    wr(A_FLAG, 16'h0001);
    rd(A_FLAG, v); chk("R9", "other bit keeps", v, 2);
    wr(A_FLAG, 16'h0002);
    rd(A_FLAG, v); chk("R9", "write 1 clears", v, 0);
    chk("R8", "irq drops", int'(irq), 0);
    wr(A_CTRL, 16'h0000);
  endtask

  task automatic t_wrap();
    int v;
    wr(A_REF, 16'd2);
    wr(A_CTRL, mk(0, 0, 0, 0, 0, 1, 1));
    cyc(3);
    rd(A_CNT, v); chk("R5", "free run past ref", v, 3);
    rd(A_FLAG, v); chk("R5", "match flag free run", v, 2);
    cyc(65534);
    rd(A_CNT, v); chk("R5", "wrap", v, 65537 % 65536);
    stop_timer();
  endtask

  task automatic t_toggle();
    wr(A_REF, 16'd1);
    wr(A_CTRL, mk(0, 0, 1, 0, 1, 1, 1));
    cyc(1); chk("R7", "toggle before match", int'(tmr_out), 1);
    cyc(1); chk("R7", "first toggle", int'(tmr_out), 0);
    cyc(1); chk("R7", "held low", int'(tmr_out), 0);
    cyc(1); chk("R7", "second toggle", int'(tmr_out), 1);
    cyc(2); chk("R7", "third toggle", int'(tmr_out), 0);
    wr(A_CTRL, mk(0, 0, 1, 0, 1, 1, 0));
    cyc(1);
    chk("R10", "toggle state reset", int'(tmr_out), 1);
    stop_timer();
    wr(A_REF, 16'hFFFF);
  endtask

  task automatic cap_case(int mode, logic from, logic to, int n, bit hit);
    int v;
    wr(A_CTRL, 16'h0000);
    cap_pin = from;
    cyc(4);
    wr(A_FLAG, 16'h0003);
    wr(A_CTRL, mk(0, mode, 0, 0, 0, 1, 1));
    cyc(n);
    cap_pin = to;
    cyc(5);
    if (hit) last_cap = n + 2;
    rd(A_FLAG, v); chk("R11", $sformatf("flag mode %0d %0b->%0b", mode, from, to), v, hit ? 1 : 0);
    rd(A_CAP, v);  chk("R11", $sformatf("value mode %0d %0b->%0b", mode, from, to), v, last_cap);
    chk("R8", $sformatf("capture irq mode %0d", mode), int'(irq), hit ? 1 : 0);
  endtask

  task automatic t_capture();
    cap_case(1, 1'b0, 1'b1, 10, 1'b1);
    cap_case(1, 1'b1, 1'b0, 11, 1'b0);
    cap_case(2, 1'b1, 1'b0, 12, 1'b1);
    cap_case(2, 1'b0, 1'b1, 13, 1'b0);
    cap_case(3, 1'b0, 1'b1, 14, 1'b1);
    cap_case(3, 1'b1, 1'b0, 15, 1'b1);
    cap_case(0, 1'b0, 1'b1, 16, 1'b0);
    stop_timer();
    cap_pin = 1'b0;
  endtask

  task automatic t_readonly();
    int v;
    wr(A_CAP, 16'h1234);
    rd(A_CAP, v); chk("R12", "capture write ignored", v, last_cap);
    wr(A_CNT, 16'h0055);
    rd(A_CNT, v); chk("R12", "count write ignored", v, 0);
    wr(A_CTRL, 16'hA5A4);
    rd(A_CTRL, v); chk("R12", "ctrl readback", v, 16'hA5A4);
    wr(A_REF, 16'h3C3C);
    rd(A_REF, v); chk("R12", "ref readback", v, 16'h3C3C);
    wr(A_CTRL, 16'h0000);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_prescale();
    t_sources();
    t_pin();
    t_restart_pulse();
    t_irq_flags();
    t_wrap();
    t_toggle();
    t_capture();
    t_readonly();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule